// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Execution Unit

This unit performs the byte-wide shift, rotate and single-bit operations of an 8-bit processor core. Each operation takes one operand byte, an operation code, a bit index and the current flag byte. It returns a result byte and a new flag byte. It handles the eight prefixed shift and rotate forms, including the shift that forces bit 0 to one. It handles bit test, bit clear and bit set. It also handles the short accumulator rotate-right, whose flag rules differ from those of the prefixed rotates.

When the operand comes from memory, the unit computes the effective address. In the plain memory form the address is the HL pair. In the indexed form it is an index base plus a sign-extended 8-bit displacement. The unit raises a write strobe for the modified byte. In the indexed form it can also raise a copy strobe, which sends the result to a named register. Instruction fetch and the memory bus are handled elsewhere.

All results are computed combinationally and captured in one output register stage. A result therefore appears one clock after its input is presented.

Top module: `srb_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid_o` is high after that edge and the outputs carry the result of that input. When `in_valid` is low, `out_valid_o`, `mem_wr_o` and `copy_we_o` fall, and `result_o`, `flags_o`, `addr_o` and `copy_reg_o` hold their previous values.
- R2: Operation code 0 rotates left circularly (bit 7 goes to bit 0 and to carry). Code 1 rotates right circularly (bit 0 goes to bit 7 and to carry).
- R3: Code 2 rotates left through carry: the result is {operand[6:0], carry in} and the new carry is operand bit 7. Code 3 rotates right through carry: the result is {carry in, operand[7:1]} and the new carry is operand bit 0.
- R4: Code 4 shifts left and fills with zero. Code 5 shifts right and keeps bit 7. Code 7 shifts right and fills with zero. In each case the bit shifted out becomes the carry.
- R5: Code 6 shifts left and forces bit 0 to one, giving {operand[6:0], 1}. The new carry is operand bit 7.
- R6: The flag byte has sign at bit 7, zero at 6, Y at 5, half-carry at 4, X at 3, parity/overflow at 2, subtract at 1 and carry at 0. For codes 0 to 7, the flags are set from the result as follows: sign is result bit 7, and zero is set when the result is zero. Parity is set when the result has even parity. X is result bit 3 and Y is result bit 5. Half-carry and subtract are cleared.
- R7: Code 11, the accumulator rotate-right, gives the same result and carry as code 1. It clears half-carry and subtract, and X and Y come from result bits 3 and 5. Sign, zero and parity pass through from `flags_i` unchanged.
- R8: Code 8 tests bit `bit_i` and returns the operand unchanged. Zero is the inverse of the tested bit, and parity/overflow equals zero. Half-carry is set and subtract is cleared. Sign is set only when bit 7 is tested and is one. Carry is unchanged. In the register form (`amode_i` 0 or 3), X and Y are operand bits 3 and 5.
- R9: For code 8 with a memory operand, X and Y are bits 3 and 5 of a byte chosen by the addressing mode. In the indexed form that byte is the effective address high byte. In the HL form it is `wz_hi_i`.
- R10: Code 9 clears bit `bit_i` and code 10 sets it. Codes 12 to 15 return the operand unchanged. For codes 9, 10 and 12 to 15, the flags equal `flags_i`.
- R11: The effective address depends on `amode_i`. Mode 1 gives `hl_i`. Mode 2 gives `xbase_i` plus sign-extended `disp_i`, modulo 2^16. Modes 0 and 3 give 0.
- R12: `mem_wr_o` is high for a valid input in mode 1 or 2 whose code is neither 8 nor 11. `copy_we_o` is high only when `mem_wr_o` is high, the mode is 2 and `copy_en_i` is set. In that case `copy_reg_o` carries `copy_reg_i`.
- R13: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation is valid |
| op_i | input | 4 | Operation code |
| bit_i | input | 3 | Bit index for codes 8 to 10 |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flags |
| amode_i | input | 2 | 0 register, 1 HL memory, 2 indexed memory, 3 register |
| hl_i | input | 16 | HL pair |
| xbase_i | input | 16 | Index register base |
| disp_i | input | 8 | Signed displacement |
| wz_hi_i | input | 8 | High byte of the internal address latch |
| copy_en_i | input | 1 | Request a copy of the result to a register |
| copy_reg_i | input | 3 | Destination register for the copy |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flags |
| addr_o | output | 16 | Effective address |
| mem_wr_o | output | 1 | Write the result back to memory |
| copy_we_o | output | 1 | Write the result to `copy_reg_o` |
| copy_reg_o | output | 3 | Register that receives the copy |

## Verification
The hardest case to reach is a bit test on an indexed operand in which the displacement is negative and carries into the address high byte. Only then do the X and Y flags expose whether the sum was formed and sign-extended correctly, rather than using the base or `wz_hi_i`. The stimulus therefore includes directed bit tests with displacements at the sign boundary around page edges. A long pseudo-random stream follows, and it mixes all four addressing modes, idle cycles and random carry inputs. A behavioural model written from the requirements is compared against the outputs on every clock, including the hold behaviour during idle cycles.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SLS  = 4'd6,
    OP_SRL  = 4'd7,
    OP_BIT  = 4'd8,
    OP_RES  = 4'd9,
    OP_SET  = 4'd10,
    OP_RRCA = 4'd11
  } srb_op_e;

  typedef enum logic [1:0] {
    AM_REG  = 2'd0,
    AM_HL   = 2'd1,
    AM_IDX  = 2'd2,
    AM_REG2 = 2'd3
  } srb_amode_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_Y = 5;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/srb_shift_core.sv
`timescale 1ns/1ps
module srb_shift_core
  import srb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  srb_op_e      op,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    res  = a;
    cout = cin;
    unique case (op)
      OP_RLC:          begin res = {a[W-2:0], a[W-1]};   cout = a[W-1]; end
      OP_RRC, OP_RRCA: begin res = {a[0], a[W-1:1]};     cout = a[0];   end
      OP_RL:           begin res = {a[W-2:0], cin};      cout = a[W-1]; end
      OP_RR:           begin res = {cin, a[W-1:1]};      cout = a[0];   end
      OP_SLA:          begin res = {a[W-2:0], 1'b0};     cout = a[W-1]; end
      OP_SRA:          begin res = {a[W-1], a[W-1:1]};   cout = a[0];   end
      OP_SLS:          begin res = {a[W-2:0], 1'b1};     cout = a[W-1]; end
      OP_SRL:          begin res = {1'b0, a[W-1:1]};     cout = a[0];   end
      default:         begin res = a;                    cout = cin;    end
    endcase
  end

  // Circular rotates keep the count of ones; rotates through carry keep it across the carry ring.
  always_comb begin
    if (op == OP_RLC || op == OP_RRC || op == OP_RRCA)
      p_rot_ones_r2: assert ($countones(res) == $countones(a));
    if (op == OP_RL || op == OP_RR)
      p_carry_ring_r3: assert ($countones(res) + int'(cout) == $countones(a) + int'(cin));
    if (op == OP_SLS)
      p_low_forced_r5: assert (res[0] == 1'b1);
  end
endmodule

// File: rtl/srb_bit_core.sv
`timescale 1ns/1ps
module srb_bit_core
  import srb_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  srb_op_e       op,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  res,
  output logic          tested
);
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign hit[i] = (idx == IW'(i));
    always_comb begin
      if (hit[i] && op == OP_SET)      res[i] = 1'b1;
      else if (hit[i] && op == OP_RES) res[i] = 1'b0;
      else                             res[i] = a[i];
    end
  end

  assign tested = |(a & hit);

  always_comb begin
    p_one_bit_touched_r10: assert ($countones(res ^ a) <= 1);
    if (op == OP_SET) p_set_lands_r10: assert (res[idx] == 1'b1);
    if (op == OP_RES) p_res_lands_r10: assert (res[idx] == 1'b0);
  end
endmodule

// File: rtl/srb_addr_gen.sv
`timescale 1ns/1ps
module srb_addr_gen
  import srb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  srb_amode_e    mode,
  input  logic [AW-1:0] hl,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] addr,
  output logic          is_mem,
  output logic          is_idx
);
  logic [AW-1:0] disp_ext;
  assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};

  always_comb begin
    unique case (mode)
      AM_HL:   begin addr = hl;              is_mem = 1'b1; is_idx = 1'b0; end
      AM_IDX:  begin addr = base + disp_ext; is_mem = 1'b1; is_idx = 1'b1; end
      default: begin addr = '0;              is_mem = 1'b0; is_idx = 1'b0; end
    endcase
  end

  always_comb begin
    if (mode == AM_IDX) p_idx_offset_r11: assert ((addr - base) == disp_ext);
    if (!is_mem) p_reg_zero_r11: assert (addr == '0);
  end
endmodule

// File: rtl/srb_unit.sv
`timescale 1ns/1ps
module srb_unit
  import srb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int RW = 3,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op_i,
  input  logic [IW-1:0] bit_i,
  input  logic [DW-1:0] operand_i,
  input  logic [7:0]    flags_i,
  input  logic [1:0]    amode_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] xbase_i,
  input  logic [7:0]    disp_i,
  input  logic [7:0]    wz_hi_i,
  input  logic          copy_en_i,
  input  logic [RW-1:0] copy_reg_i,
  output logic          out_valid_o,
  output logic [DW-1:0] result_o,
  output logic [7:0]    flags_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_wr_o,
  output logic          copy_we_o,
  output logic [RW-1:0] copy_reg_o
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  srb_op_e    op;
  srb_amode_e am;
  assign op = srb_op_e'(op_i);
  assign am = srb_amode_e'(amode_i);

  logic [DW-1:0] sh_res, bt_res;
  logic          sh_c, bt_hit;
  logic [AW-1:0] addr_d;
  logic          is_mem, is_idx;

  srb_shift_core #(.W(DW)) u_shift (
    .a(operand_i), .op(op), .cin(flags_i[FL_C]), .res(sh_res), .cout(sh_c)
  );

  srb_bit_core #(.W(DW)) u_bit (
    .a(operand_i), .op(op), .idx(bit_i), .res(bt_res), .tested(bt_hit)
  );

  srb_addr_gen #(.AW(AW), .DW(8)) u_addr (
    .mode(am), .hl(hl_i), .base(xbase_i), .disp(disp_i),
    .addr(addr_d), .is_mem(is_mem), .is_idx(is_idx)
  );

  // Next state
  logic [DW-1:0] res_d;
  logic [7:0]    flg_d;
  logic [7:0]    xy_src;
  logic          writes, mw_d, cw_d;

  always_comb begin
    res_d  = operand_i;
    flg_d  = flags_i;
    xy_src = operand_i[7:0];
    unique case (op)
      OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SLS, OP_SRL: begin
        res_d       = sh_res;
        flg_d[FL_S] = sh_res[DW-1];
        flg_d[FL_Z] = (sh_res == '0);
        flg_d[FL_Y] = sh_res[5];
        flg_d[FL_H] = 1'b0;
        flg_d[FL_X] = sh_res[3];
        flg_d[FL_P] = ~^sh_res;
        flg_d[FL_N] = 1'b0;
        flg_d[FL_C] = sh_c;
      end
      OP_RRCA: begin
        res_d       = sh_res;
        flg_d[FL_Y] = sh_res[5];
        flg_d[FL_H] = 1'b0;
        flg_d[FL_X] = sh_res[3];
        flg_d[FL_N] = 1'b0;
        flg_d[FL_C] = sh_c;
      end
      OP_BIT: begin
        if (is_idx)      xy_src = addr_d[AW-1 -: 8];
        else if (is_mem) xy_src = wz_hi_i;
        flg_d[FL_S] = bt_hit && (bit_i == IW'(DW-1));
        flg_d[FL_Z] = ~bt_hit;
        flg_d[FL_P] = ~bt_hit;
        flg_d[FL_H] = 1'b1;
        flg_d[FL_N] = 1'b0;
        flg_d[FL_Y] = xy_src[5];
        flg_d[FL_X] = xy_src[3];
      end
      OP_RES, OP_SET: res_d = bt_res;
      default: res_d = operand_i;
    endcase
    writes = is_mem && (op != OP_BIT) && (op != OP_RRCA);
    mw_d   = in_valid && writes;
    cw_d   = in_valid && writes && is_idx && copy_en_i;
  end

  // Output register stage
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_o <= 1'b0;
      mem_wr_o    <= 1'b0;
      copy_we_o   <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
      addr_o      <= '0;
      copy_reg_o  <= '0;
    end else begin
      out_valid_o <= in_valid;
      mem_wr_o    <= mw_d;
      copy_we_o   <= cw_d;
      if (in_valid) begin
        result_o   <= res_d;
        flags_o    <= flg_d;
        addr_o     <= addr_d;
        copy_reg_o <= copy_reg_i;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid_o);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(result_o) && $stable(flags_o) && !mem_wr_o));
  p_copy_implies_write_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    copy_we_o |-> (mem_wr_o && out_valid_o));
  p_bit_flags_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_o && $past(op_i) == 4'(OP_BIT)) |->
      (flags_o[FL_P] == flags_o[FL_Z] && flags_o[FL_H] && !flags_o[FL_N]));
  p_setres_flags_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_o && ($past(op_i) == 4'(OP_SET) || $past(op_i) == 4'(OP_RES))) |->
      (flags_o == $past(flags_i)));
  p_acc_keeps_szp_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_o && $past(op_i) == 4'(OP_RRCA)) |->
      (flags_o[FL_S] == $past(flags_i[FL_S]) && flags_o[FL_Z] == $past(flags_i[FL_Z])
       && flags_o[FL_P] == $past(flags_i[FL_P])));
endmodule

// File: tb/tb_srb_unit.sv
`timescale 1ns/1ps
module tb_srb_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_i;
  logic [2:0]  bit_i;
  logic [7:0]  operand_i, flags_i, disp_i, wz_hi_i;
  logic [1:0]  amode_i;
  logic [15:0] hl_i, xbase_i;
  logic        copy_en_i;
  logic [2:0]  copy_reg_i;
  logic        out_valid_o, mem_wr_o, copy_we_o;
  logic [7:0]  result_o, flags_o;
  logic [15:0] addr_o;
  logic [2:0]  copy_reg_o;

  int errors = 0;
  int checks = 0;

  int e_valid = 0, e_res = 0, e_flg = 0, e_addr = 0, e_mw = 0, e_cw = 0, e_cr = 0;
  string e_tr = "R13", e_tf = "R13";

  always #2 clk = ~clk;

  srb_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .bit_i(bit_i),
    .operand_i(operand_i), .flags_i(flags_i), .amode_i(amode_i), .hl_i(hl_i),
    .xbase_i(xbase_i), .disp_i(disp_i), .wz_hi_i(wz_hi_i), .copy_en_i(copy_en_i),
    .copy_reg_i(copy_reg_i), .out_valid_o(out_valid_o), .result_o(result_o),
    .flags_o(flags_o), .addr_o(addr_o), .mem_wr_o(mem_wr_o), .copy_we_o(copy_we_o),
    .copy_reg_o(copy_reg_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int even_par(input int v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (v >> k) & 1;
    return ((n % 2) == 0) ? 1 : 0;
  endfunction

  // Behavioural model of the requirements.
  task automatic ref_calc(input int op, input int bi, input int a, input int f, input int am,
                          input int hl, input int xb, input int d, input int wz, input int ce,
                          output int r, output int nf, output int ad, output int mw,
                          output int cw, output string tr, output string tf);
    int c, nc, b, src, sd;
    c  = f & 1;
    nc = c;
    sd = (d >= 128) ? d - 256 : d;
    if (am == 1)      ad = hl;
    else if (am == 2) ad = (xb + sd + 65536) % 65536;
    else              ad = 0;
    r = a; nf = f; tr = "R10"; tf = "R10";
    case (op)
      0: begin r = ((a * 2) % 256) + (a / 128); nc = a / 128; tr = "R2"; end
      1: begin r = (a / 2) + (a % 2) * 128;     nc = a % 2;   tr = "R2"; end
      2: begin r = ((a * 2) % 256) + c;         nc = a / 128; tr = "R3"; end
      3: begin r = (a / 2) + c * 128;           nc = a % 2;   tr = "R3"; end
      4: begin r = (a * 2) % 256;               nc = a / 128; tr = "R4"; end
      5: begin r = (a / 2) + (a / 128) * 128;   nc = a % 2;   tr = "R4"; end
      6: begin r = ((a * 2) % 256) + 1;         nc = a / 128; tr = "R5"; end
      7: begin r = a / 2;                       nc = a % 2;   tr = "R4"; end
      8: begin
        b  = (a >> bi) & 1;
        tr = "R8";
        tf = (am == 1 || am == 2) ? "R9" : "R8";
        if (am == 2)      src = ad / 256;
        else if (am == 1) src = wz;
        else              src = a;
        nf = (f & 1) + 16 + (src & 32) + (src & 8);
        if (b == 0) nf += 64 + 4;
        if (bi == 7 && b == 1) nf += 128;
      end
      9:  r = a & (255 - (1 << bi));
      10: r = a | (1 << bi);
      11: begin
        r  = (a / 2) + (a % 2) * 128;
        nf = (f & (128 + 64 + 4)) + (r & 32) + (r & 8) + (a % 2);
        tr = "R7"; tf = "R7";
      end
      default: r = a;
    endcase
    if (op <= 7) begin
      tf = "R6";
      nf = (r & 128) + (r & 32) + (r & 8) + nc;
      if (r == 0) nf += 64;
      if (even_par(r) == 1) nf += 4;
    end
    mw = ((am == 1 || am == 2) && op != 8 && op != 11) ? 1 : 0;
    cw = (mw == 1 && am == 2 && ce == 1) ? 1 : 0;
  endtask

  task automatic compare();
    chk("R1 out_valid", int'(out_valid_o), e_valid);
    chk({e_tr, " result"}, int'(result_o), e_res);
    chk({e_tf, " flags"}, int'(flags_o), e_flg);
    chk("R11 addr", int'(addr_o), e_addr);
    chk("R12 mem_wr", int'(mem_wr_o), e_mw);
    chk("R12 copy_we", int'(copy_we_o), e_cw);
    if (e_cw == 1) chk("R12 copy_reg", int'(copy_reg_o), e_cr);
  endtask

  task automatic step(input int v, input int op, input int bi, input int a, input int f,
                      input int am, input int hl, input int xb, input int d, input int wz,
                      input int ce, input int cr);
    int r, nf, ad, mw, cw;
    string tr, tf;
    @(negedge clk);
    compare();
    in_valid   = (v != 0);
    op_i       = 4'(op);
    bit_i      = 3'(bi);
    operand_i  = 8'(a);
    flags_i    = 8'(f);
    amode_i    = 2'(am);
    hl_i       = 16'(hl);
    xbase_i    = 16'(xb);
    disp_i     = 8'(d);
    wz_hi_i    = 8'(wz);
    copy_en_i  = (ce != 0);
    copy_reg_i = 3'(cr);
    if (v != 0) begin
      ref_calc(op, bi, a, f, am, hl, xb, d, wz, ce, r, nf, ad, mw, cw, tr, tf);
      e_valid = 1; e_res = r; e_flg = nf; e_addr = ad; e_mw = mw; e_cw = cw; e_cr = cr;
      e_tr = tr; e_tf = tf;
    end else begin
      e_valid = 0; e_mw = 0; e_cw = 0;
      e_tr = "R1 hold"; e_tf = "R1 hold";
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst_n = 1'b0; in_valid = 1'b0; op_i = '0; bit_i = '0; operand_i = '0; flags_i = '0;
    amode_i = '0; hl_i = '0; xbase_i = '0; disp_i = '0; wz_hi_i = '0; copy_en_i = 1'b0;
    copy_reg_i = '0;
    repeat (3) @(negedge clk);
    chk("R13 reset out_valid", int'(out_valid_o), 0);
    chk("R13 reset result", int'(result_o), 0);
    chk("R13 reset flags", int'(flags_o), 0);
    chk("R13 reset addr", int'(addr_o), 0);
    chk("R13 reset strobes", int'({mem_wr_o, copy_we_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed corners: R3 carry into bit 7, R5 forced bit 0, R7 flag pass-through.
    step(1, 3, 0, 8'h01, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    step(1, 3, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6, 0, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6, 0, 8'h7F, 8'hFF, 1, 16'h4000, 0, 0, 0, 1, 5);
    step(1, 11, 0, 8'h01, 8'hC4, 0, 0, 0, 0, 0, 0, 0);
    step(1, 11, 0, 8'h28, 8'h00, 2, 0, 16'h1000, 0, 0, 1, 1);
    step(1, 8, 7, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8, 3, 8'hF7, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    // R9: negative displacement crossing into the page below.
    step(1, 8, 0, 8'h01, 8'h00, 2, 16'hFFFF, 16'h2800, 8'hF8, 8'h00, 1, 3);
    step(1, 8, 5, 8'h00, 8'h00, 2, 0, 16'h0000, 8'h80, 8'h00, 0, 0);
    step(1, 8, 1, 8'h02, 8'h00, 1, 16'h2830, 0, 0, 8'h28, 0, 0);
    step(1, 10, 4, 8'h00, 8'hA5, 2, 0, 16'hFFF0, 8'h7F, 0, 1, 6);
    step(1, 9, 0, 8'hFF, 8'h5A, 2, 0, 16'h0010, 8'hF0, 0, 0, 2);
    step(0, 0, 0, 8'h55, 8'hFF, 1, 0, 0, 0, 0, 1, 1);
    step(0, 1, 0, 8'hAA, 8'h00, 2, 0, 0, 0, 0, 1, 1);
    step(1, 14, 0, 8'h3C, 8'h99, 3, 16'h1234, 0, 0, 0, 1, 7);

    s = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      int v, op, am;
      s = s * 32'd1664525 + 32'd1013904223;
      v  = (s[31:29] != 3'd0) ? 1 : 0;
      op = int'(s[27:24]);
      am = int'(s[23:22]);
      s = s * 32'd1664525 + 32'd1013904223;
      step(v, op, int'(s[2:0]), int'(s[31:24]), int'(s[23:16]), am,
           int'(s[15:0]), int'({s[7:0], s[31:24]}), int'(s[13:6]), int'(s[21:14]),
           int'(s[3]), int'(s[6:4]));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule